// File: doc/BRIEF.md
# I2C Master Clock Pacer

This block produces the SCL waveform of an I2C master and places SDA changes in the right order around it. Both lines are open-drain. The block only ever pulls a line low or lets it go, and it reads each line back through its own pad input. The bit rate is chosen by the master alone, through a divider value. No slave takes part in choosing it.

The low phase and the high phase each last N = 8 + `div_val` system clocks. The nominal SCL period is therefore 16 + 2·`div_val` clocks. The high phase is timed from the moment the synchronized SCL input is first seen high, not from the moment SCL is released. A weak pull-up or a slave stretching the clock therefore makes the period longer, and never makes the high time shorter.

A controller sends one request at a time over a valid/ready handshake. The request kinds are:
- START condition
- STOP condition
- one data bit

`cmd_ready` is high only while the block is idle. While it is low, any `cmd_valid` is neither taken nor remembered. The requester must hold the op and the bit steady until the cycle in which both `cmd_valid` and `cmd_ready` are high. Byte framing, addressing and arbitration belong to the logic around this block.

Top module: `scl_pacer`

## Requirements
- R1: While reset is asserted and after it is released, `scl_pull` and `sda_pull` are 0 (both lines released), `busy` is 0 and `cmd_ready` is 1.
- R2: A request is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `busy` is 1 and `cmd_ready` is 0 until the request completes. A `cmd_valid` of any op while `cmd_ready` is 0 has no effect. The `cmd_op` encodings are 2'b00 START, 2'b01 STOP, and 2'b10 or 2'b11 data bit.
- R3: N = 8 + `div_val` is captured on the accepting edge. Changes to `div_val` while `busy` is 1 do not alter the request in flight.
- R4: For a data bit, `sda_pull` takes the value !`cmd_bit` on the accepting edge, and SCL is released exactly N clocks later.
- R5: After SCL is released, the high phase lasts N clocks. It starts on the first cycle in which the two-flop synchronized SCL input is 1. If the pad rises right after an edge, SCL is seen high for N+2 sampled cycles. If it rises mid-cycle, it is seen high for N+1.
- R6: While something else holds SCL low after its release, the block keeps SCL released, stays busy and counts no high time.
- R7: At the end of a data bit's high phase, SCL is pulled low and the request completes. `sda_pull` never changes while SCL is high during a data bit.
- R8: A START releases SDA during its setup phase. After the high phase it pulls SDA while SCL is high, holds that for N clocks, then pulls SCL. It ends with `scl_pull`=1 and `sda_pull`=1.
- R9: A STOP pulls SDA during its setup phase. After the high phase it releases SDA while SCL is high and holds for N clocks. It ends with both lines released.
- R10: `rx_bit` captures the synchronized SDA input on the last cycle of each data bit's high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Bit-rate divider; each phase lasts 8 + div_val clocks |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle and able to take a request |
| cmd_op | input | 2 | Request kind: 00 START, 01 STOP, 1x data bit |
| cmd_bit | input | 1 | Data bit to place on SDA |
| busy | output | 1 | A request is in progress |
| rx_bit | output | 1 | SDA level sampled at the end of the last bit's high phase |
| scl_pull | output | 1 | 1 pulls the SCL pad low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the SDA pad low, 0 releases it |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |

## Verification
The bench models a slave that holds SCL low for 7 and for 20 cycles after release. A design that counted high time from the release command, rather than from the sensed level, would cut the visible high pulse short or remove it altogether. High widths are scored against N for three divider values, and the divider is changed in the middle of a bit. A pacer that tracks `div_val` live would produce a high pulse of the wrong length. The bench also counts clocks from each SDA change to the SCL release, and records every SDA edge made while SCL is high. A swapped START/STOP ordering, or a data change while SCL is high, shows up as a wrong event count. A STOP offered while a bit is in progress must leave SCL pulled at the end, which catches a handshake that takes requests while busy.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_STOP  = 2'b01,
    OP_BIT   = 2'b10,
    OP_BIT2  = 2'b11
  } pacer_op_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SETUP  = 3'd1,
    S_WAIT_HI = 3'd2,
    S_HIGH   = 3'd3,
    S_TAIL   = 3'd4
  } pacer_state_e;

endpackage

// File: rtl/scl_pacer_sync.sv
module scl_pacer_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // Released open-drain lines read high, so each stage resets to 1.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '1;
      end else if (g == 0) begin
        stage_q[g] <= d;
      end else begin
        stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scl_pacer_timer.sv
module scl_pacer_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = run && (cnt_q == limit - 1'b1);

  // R5: a running phase never passes its length
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int BASE_CLKS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             busy,
  output logic             rx_bit,
  output logic             scl_pull,
  output logic             sda_pull,
  input  logic             scl_in,
  input  logic             sda_in
);
  localparam int CNT_W = DIV_W + 1;

  pacer_state_e     state_q;
  pacer_op_e        op_q;
  pacer_op_e        op_in;
  logic [CNT_W-1:0] n_q;
  logic             scl_pull_q, sda_pull_q, rx_q;
  logic             scl_s, sda_s;
  logic             ph_load, ph_run, ph_last;
  logic [CNT_W-1:0] ph_load_val;

  assign op_in = pacer_op_e'(cmd_op);

  scl_pacer_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     ({scl_s, sda_s})
  );

  scl_pacer_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_load_val),
    .run      (ph_run),
    .limit    (n_q),
    .last     (ph_last)
  );

  assign ph_run = (state_q == S_SETUP) || (state_q == S_HIGH) || (state_q == S_TAIL);

  always_comb begin
    ph_load     = 1'b0;
    ph_load_val = '0;
    unique case (state_q)
      S_IDLE: begin
        ph_load = cmd_valid;
      end
      S_WAIT_HI: begin
        // The first cycle seen high already counts as one.
        ph_load     = scl_s;
        ph_load_val = CNT_W'(1);
      end
      S_HIGH: begin
        ph_load = ph_last && ((op_q == OP_START) || (op_q == OP_STOP));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      op_q       <= OP_BIT;
      n_q        <= CNT_W'(BASE_CLKS);
      scl_pull_q <= 1'b0;
      sda_pull_q <= 1'b0;
      rx_q       <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q    <= op_in;
            n_q     <= CNT_W'(BASE_CLKS) + CNT_W'(div_val);
            state_q <= S_SETUP;
            unique case (op_in)
              OP_START: sda_pull_q <= 1'b0;
              OP_STOP:  sda_pull_q <= 1'b1;
              default:  sda_pull_q <= !cmd_bit;
            endcase
          end
        end
        S_SETUP: begin
          if (ph_last) begin
            scl_pull_q <= 1'b0;
            state_q    <= S_WAIT_HI;
          end
        end
        S_WAIT_HI: begin
          if (scl_s) state_q <= S_HIGH;
        end
        S_HIGH: begin
          if (ph_last) begin
            unique case (op_q)
              OP_START: begin
                sda_pull_q <= 1'b1;
                state_q    <= S_TAIL;
              end
              OP_STOP: begin
                sda_pull_q <= 1'b0;
                state_q    <= S_TAIL;
              end
              default: begin
                scl_pull_q <= 1'b1;
                rx_q       <= sda_s;
                state_q    <= S_IDLE;
              end
            endcase
          end
        end
        S_TAIL: begin
          if (ph_last) begin
            if (op_q == OP_START) scl_pull_q <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign scl_pull  = scl_pull_q;
  assign sda_pull  = sda_pull_q;
  assign rx_bit    = rx_q;

  // R2: an accepted request makes the block busy on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R3: the captured divider does not move while a request is in flight
  a_r3_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(n_q));

  // R6: while SCL is still sensed low, keep waiting with SCL released
  a_r6_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_HI && !scl_s) |=> (state_q == S_WAIT_HI && !scl_pull_q));

  // R7: SDA holds still through the high phase until its final cycle
  a_r7_sda_still_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HIGH && !ph_last) |=> $stable(sda_pull_q));
endmodule

// File: tb/sim_scl_pacer.sv
module sim_scl_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam int DIV_W = 8;

  localparam logic [1:0] OPC_START = 2'b00;
  localparam logic [1:0] OPC_STOP  = 2'b01;
  localparam logic [1:0] OPC_BIT   = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_bit = 1'b0;
  logic cmd_ready, busy, rx_bit, scl_pull, sda_pull;
  logic slv_hold = 1'b0;
  logic slv_sda = 1'b0;
  logic scl_in, sda_in;

  int checks = 0;
  int errors = 0;
  int start_evt = 0, stop_evt = 0, bad_evt = 0;
  logic [1:0] cur_op = OPC_START;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = !(scl_pull || slv_hold);
  assign sda_in = !(sda_pull || slv_sda);

  scl_pacer #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .div_val(div_val),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .busy(busy), .rx_bit(rx_bit), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .scl_in(scl_in), .sda_in(sda_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: samples a quarter period after each rising edge.
  logic prev_scl = 1'b1;
  logic prev_sda = 1'b0;
  bit   meas = 1'b0;
  int   run_len = 0;
  always @(posedge clk) begin
    #Q;
    if (rst_n) begin
      if (scl_in && !prev_scl) begin
        meas = busy && (cur_op == OPC_BIT);
        run_len = 1;
      end else if (scl_in) begin
        run_len++;
      end else if (prev_scl && meas) begin
        meas = 1'b0;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected high pulse", run_len, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(run_len == e, "R5 SCL high width", run_len, e);
        end
      end
      if (sda_pull != prev_sda && scl_in) begin
        if (cur_op == OPC_BIT) bad_evt++;
        else if (sda_pull) start_evt++;
        else stop_evt++;
      end
      prev_scl = scl_in;
      prev_sda = sda_pull;
    end
  end

  task automatic sample();
    @(posedge clk); #Q;
  endtask

  task automatic send(input logic [1:0] op, input logic b, input int stretch,
                      input logic slv, input bit bp, input int new_div);
    int n;
    int cnt;
    n = 8 + int'(div_val);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cur_op = op;
    slv_sda = slv;
    if (stretch > 0) slv_hold = 1'b1;
    if (op == OPC_BIT) exp_q.push_back((stretch > 0) ? n + 1 : n + 2);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    sample();
    chk(busy && !cmd_ready, "R2 busy after accept", int'(busy), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (new_div >= 0) div_val = DIV_W'(new_div);
    if (bp) begin
      repeat (3) begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OPC_STOP;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
    end else if (op == OPC_BIT) begin
      cnt = 0;
      while (scl_pull) begin
        cnt++;
        sample();
      end
      chk(cnt == n, "R4 SDA-to-SCL-release clocks", cnt, n);
      for (int k = 0; k < stretch; k++) begin
        sample();
        chk(!scl_pull && busy && !scl_in, "R6 wait while stretched", int'(scl_pull), 0);
      end
      if (stretch > 0) begin
        @(negedge clk);
        slv_hold = 1'b0;
      end
    end
    sample();
    while (busy) sample();
    chk(cmd_ready, "R2 ready after completion", int'(cmd_ready), 1);
    if (op == OPC_START) begin
      chk(scl_pull && sda_pull, "R8 START end state", {scl_pull, sda_pull}, 3);
    end else if (op == OPC_STOP) begin
      chk(!scl_pull && !sda_pull, "R9 STOP end state", {scl_pull, sda_pull}, 0);
    end else begin
      chk(scl_pull, "R7 SCL pulled after bit", int'(scl_pull), 1);
      chk(rx_bit == (b && !slv), "R10 sampled SDA", int'(rx_bit), int'(b && !slv));
      if (bp) chk(scl_pull && (sda_pull == !b), "R2 request while busy ignored",
                  {scl_pull, sda_pull}, {1'b1, !b});
    end
    slv_sda = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!scl_pull && !sda_pull, "R1 lines released in reset", {scl_pull, sda_pull}, 0);
    chk(!busy && cmd_ready, "R1 idle in reset", {busy, cmd_ready}, 1);
    @(negedge clk);
    rst_n = 1'b1;
    sample();
    chk(!scl_pull && !sda_pull && !busy && cmd_ready, "R1 state after reset",
        {scl_pull, sda_pull, busy, cmd_ready}, 1);

    div_val = 8'd0;
    send(OPC_START, 1'b0, 0, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b1, 0, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b0, 0, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b1, 0, 1'b1, 1'b0, -1);
    send(OPC_BIT,   1'b1, 0, 1'b0, 1'b0, -1);
    send(OPC_STOP,  1'b0, 0, 1'b0, 1'b0, -1);

    div_val = 8'd5;
    send(OPC_START, 1'b0, 0, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b0, 7, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b1, 20, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b0, 0, 1'b0, 1'b0, 30);  // R3: divider moved mid-bit
    div_val = 8'd5;
    send(OPC_BIT,   1'b1, 0, 1'b0, 1'b1, -1);
    send(OPC_STOP,  1'b0, 0, 1'b0, 1'b0, -1);

    div_val = 8'd20;
    send(OPC_START, 1'b0, 0, 1'b0, 1'b0, -1);
    send(OPC_BIT,   1'b1, 0, 1'b0, 1'b0, -1);
    send(OPC_STOP,  1'b0, 0, 1'b0, 1'b0, -1);

    repeat (4) sample();
    chk(start_evt == 3, "R8 SDA pulled while SCL high", start_evt, 3);
    chk(stop_evt == 3, "R9 SDA released while SCL high", stop_evt, 3);
    chk(bad_evt == 0, "R7 no data change while SCL high", bad_evt, 0);
    chk(exp_q.size() == 0, "R3 R5 all bit pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule